// File: doc/BRIEF.md
# Memory-Card Host Register File

This block is the software-visible register file of a memory-card host controller. A processor reaches it through a plain 32-bit register bus: a word address, a write strobe, a read strobe, write data, and read data that is valid in the same cycle as the read strobe. The block holds the control registers and the status word. It raises two interrupt lines, each the OR of the status bits that its own mask enables. It connects to the command engine and the data engine through start pulses, completion pulses and status-set inputs.

The block does not store FIFO data. Bus accesses to the FIFO window become push and pop strobes toward an external FIFO. Reading a word out of that window puts data movement on hold. A later read of the status word or of the FIFO word count lets the data engine run again. Only the low eleven status bits are event flags that software can clear by writing ones. The upper bits show live FIFO and activity conditions, and only the engines change them.

Top module: `cardhost_regs`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low, and no start pulse, FIFO strobe or run level is asserted.
- R2: A write to power (word 0x00), clock (0x04) or data control (0x2C) keeps only bits 7:0. A write to data length (0x28) keeps only bits 15:0. Argument (0x08), data timer (0x24), mask 0 (0x3C) and mask 1 (0x40) keep all 32 bits.
- R3: Status (0x34) is 22 bits. A write to clear (0x38) drops the status bits whose written bit is 1, but only within bits 10:0. When a status-set input and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: interrupt line A is high exactly when status AND mask 0 is nonzero, and line B follows the same rule with mask 1. Both are updated from the registered status.
- R5: Word addresses 0xFE0 to 0xFFC read 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, with the byte in bits 7:0 and zeros above it.
- R6: FIFO count (0x48) reads (data count + 3) >> 2, computed without overflow over the full 16-bit count.
- R7: A data-control write with bit 0 set loads data count (0x30) from data length and produces a one-cycle data-start pulse. Each data-tick input decrements a nonzero count. At zero the count stays at zero.
- R8: A read in the FIFO window (0x80 to 0xBC) while the FIFO is not empty returns the FIFO's word, pulses the pop strobe in that cycle and puts data movement on hold, so data-run goes low. A read in the window while the FIFO is empty returns zero, with no pop and no hold.
- R9: A read of status or of FIFO count releases the hold. Data-run is high whenever data-control bit 0 is set and no hold is pending.
- R10: A command write (0x0C) stores all 32 bits. If bit 10 is set, it produces a one-cycle command-start pulse. Bit 10 reads back as 1 until the command-done input, then reads 0, and the other command bits are kept.
- R11: A response-load input stores the 6-bit response command (0x10) and the four response words (0x14 to 0x20, word 0 taken from input bits 31:0).
- R12: Reads of unmapped word addresses return zero, and writes to them change no register.
- R13: A write in the FIFO window pulses the push strobe, with the written word on the FIFO data output, only while data count is nonzero. Otherwise the write is dropped.
- R14: The data-idle input clears data-control bit 0 and leaves bits 7:1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_a | output | 1 | Status AND mask 0 nonzero |
| irq_b | output | 1 | Status AND mask 1 nonzero |
| cmd_start | output | 1 | One-cycle command engine start |
| cmd_done | input | 1 | Command finished; clears enable bit |
| resp_load | input | 1 | Store response inputs |
| resp_cmd_in | input | 6 | Response command index |
| resp_words | input | 128 | Four response words, word 0 lowest |
| data_start | output | 1 | One-cycle data engine start |
| data_run | output | 1 | Data engine may move data |
| data_tick | input | 1 | One byte moved; decrement count |
| data_idle | input | 1 | Data engine finished |
| status_set | input | 22 | Status bits to set this cycle |
| fifo_push | output | 1 | Push strobe toward FIFO |
| fifo_wdata | output | 32 | Word to push |
| fifo_pop | output | 1 | Pop strobe toward FIFO |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO holds no word |

## Verification
The bench writes all-ones to clear over a fully set status word. A design that cleared past bit 10 would drop the live FIFO flags. It also drives a set and a clear into the same bit in one cycle, where a wrong priority would lose an event. FIFO count is checked at zero, at 4, at 5 and at the largest length, which catches an off-by-one rounding and a carry lost out of the 16-bit sum. The bench runs the hold sequence (a popped read, then a release by status and by count read) and an empty-FIFO read. A design that treated the empty read as a pop would stall the data engine for good. The bench also checks that the command enable bit survives until the done input and that the count stays at zero under further ticks.

// File: rtl/cardhost_pkg.sv
package cardhost_pkg;

    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int IW       = AW - 2;
    localparam int ST_W     = 22;
    localparam int CLR_W    = 11;
    localparam int LEN_W    = 16;
    localparam int CTL_W    = 8;
    localparam int NIRQ     = 2;
    localparam int NRESP    = 4;
    localparam int RCMD_W   = 6;
    localparam int CMD_EN   = 10;
    localparam int FCNT_W   = LEN_W + 1;

    // word indices (byte offset >> 2)
    localparam logic [IW-1:0] W_POWER  = 10'h000;
    localparam logic [IW-1:0] W_CLOCK  = 10'h001;
    localparam logic [IW-1:0] W_ARG    = 10'h002;
    localparam logic [IW-1:0] W_CMD    = 10'h003;
    localparam logic [IW-1:0] W_RCMD   = 10'h004;
    localparam logic [IW-1:0] W_RESP0  = 10'h005;
    localparam logic [IW-1:0] W_DTIMER = 10'h009;
    localparam logic [IW-1:0] W_DLEN   = 10'h00A;
    localparam logic [IW-1:0] W_DCTRL  = 10'h00B;
    localparam logic [IW-1:0] W_DCNT   = 10'h00C;
    localparam logic [IW-1:0] W_STATUS = 10'h00D;
    localparam logic [IW-1:0] W_CLEAR  = 10'h00E;
    localparam logic [IW-1:0] W_MASK0  = 10'h00F;
    localparam logic [IW-1:0] W_MASK1  = 10'h010;
    localparam logic [IW-1:0] W_FCNT   = 10'h012;

    typedef struct packed {
        logic [CTL_W-1:0]              power;
        logic [CTL_W-1:0]              clock;
        logic [DW-1:0]                 arg;
        logic [DW-1:0]                 cmd;
        logic [RCMD_W-1:0]             rcmd;
        logic [NRESP-1:0][DW-1:0]      resp;
        logic [DW-1:0]                 dtimer;
        logic [LEN_W-1:0]              dlen;
        logic [CTL_W-1:0]              dctrl;
        logic [LEN_W-1:0]              dcnt;
        logic [NIRQ-1:0][DW-1:0]       mask;
        logic                          hold;
        logic                          cmd_start;
        logic                          data_start;
    } regs_t;

    function automatic logic in_fifo_win(input logic [IW-1:0] idx);
        return idx[IW-1:4] == 6'h02;
    endfunction

    function automatic logic in_id_area(input logic [IW-1:0] idx);
        return idx[IW-1:3] == 7'h7F;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h81;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/cardhost_status.sv
module cardhost_status
    import cardhost_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ST_W-1:0]          set_bits,
    input  logic                     clr_en,
    input  logic [CLR_W-1:0]         clr_bits,
    input  logic [NIRQ-1:0][DW-1:0]  masks,
    output logic [ST_W-1:0]          status,
    output logic [NIRQ-1:0]          irq
);
    localparam int PAD = DW - ST_W;

    logic [ST_W-1:0] status_d, status_q;
    logic [ST_W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_en ? {{(ST_W-CLR_W){1'b0}}, clr_bits} : '0;
        // a set arriving with a clear wins
        status_d = (status_q & ~clr_mask) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;

    for (genvar g = 0; g < NIRQ; g++) begin : g_irq
        assign irq[g] = |({{PAD{1'b0}}, status_q} & masks[g]);
    end

endmodule

// File: rtl/cardhost_rdmux.sv
module cardhost_rdmux
    import cardhost_pkg::*;
(
    input  logic [IW-1:0]   idx,
    input  regs_t           r,
    input  logic [ST_W-1:0] status,
    input  logic [DW-1:0]   fifo_rdata,
    input  logic            fifo_empty,
    output logic [DW-1:0]   rdata
);
    logic [FCNT_W-1:0] words_left;

    always_comb begin
        words_left = ({1'b0, r.dcnt} + FCNT_W'(3)) >> 2;
        rdata = '0;
        if (in_id_area(idx)) begin
            rdata = DW'(id_byte(idx[2:0]));
        end else if (in_fifo_win(idx)) begin
            rdata = fifo_empty ? '0 : fifo_rdata;
        end else begin
            case (idx)
                W_POWER:  rdata = DW'(r.power);
                W_CLOCK:  rdata = DW'(r.clock);
                W_ARG:    rdata = r.arg;
                W_CMD:    rdata = r.cmd;
                W_RCMD:   rdata = DW'(r.rcmd);
                W_RESP0:  rdata = r.resp[0];
                W_RESP0 + 10'd1: rdata = r.resp[1];
                W_RESP0 + 10'd2: rdata = r.resp[2];
                W_RESP0 + 10'd3: rdata = r.resp[3];
                W_DTIMER: rdata = r.dtimer;
                W_DLEN:   rdata = DW'(r.dlen);
                W_DCTRL:  rdata = DW'(r.dctrl);
                W_DCNT:   rdata = DW'(r.dcnt);
                W_STATUS: rdata = DW'(status);
                W_MASK0:  rdata = r.mask[0];
                W_MASK1:  rdata = r.mask[1];
                W_FCNT:   rdata = DW'(words_left);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cardhost_regs.sv
module cardhost_regs
    import cardhost_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic                   irq_a,
    output logic                   irq_b,
    output logic                   cmd_start,
    input  logic                   cmd_done,
    input  logic                   resp_load,
    input  logic [RCMD_W-1:0]      resp_cmd_in,
    input  logic [NRESP*DW-1:0]    resp_words,
    output logic                   data_start,
    output logic                   data_run,
    input  logic                   data_tick,
    input  logic                   data_idle,
    input  logic [ST_W-1:0]        status_set,
    output logic                   fifo_push,
    output logic [DW-1:0]          fifo_wdata,
    output logic                   fifo_pop,
    input  logic [DW-1:0]          fifo_rdata,
    input  logic                   fifo_empty
);
    regs_t           r_d, r_q;
    logic [IW-1:0]   idx;
    logic [ST_W-1:0] status_q;
    logic [NIRQ-1:0] irq;
    logic            clr_en;
    logic            win;
    logic            hold_q;
    logic            cmd_en_q;
    logic [LEN_W-1:0] dcnt_q;

    assign idx    = bus_addr[AW-1:2];
    assign win    = in_fifo_win(idx);
    assign clr_en = bus_wr && (idx == W_CLEAR);

    always_comb begin
        r_d            = r_q;
        r_d.cmd_start  = 1'b0;
        r_d.data_start = 1'b0;

        if (cmd_done)  r_d.cmd[CMD_EN] = 1'b0;
        if (data_idle) r_d.dctrl[0]    = 1'b0;
        if (data_tick && (r_q.dcnt != '0)) r_d.dcnt = r_q.dcnt - 1'b1;
        if (resp_load) begin
            r_d.rcmd = resp_cmd_in;
            r_d.resp = resp_words;
        end

        if (bus_rd) begin
            if (idx == W_STATUS || idx == W_FCNT) r_d.hold = 1'b0;
            else if (win && !fifo_empty)           r_d.hold = 1'b1;
        end

        if (bus_wr) begin
            case (idx)
                W_POWER:  r_d.power  = bus_wdata[CTL_W-1:0];
                W_CLOCK:  r_d.clock  = bus_wdata[CTL_W-1:0];
                W_ARG:    r_d.arg    = bus_wdata;
                W_CMD: begin
                    r_d.cmd       = bus_wdata;
                    r_d.cmd_start = bus_wdata[CMD_EN];
                end
                W_DTIMER: r_d.dtimer = bus_wdata;
                W_DLEN:   r_d.dlen   = bus_wdata[LEN_W-1:0];
                W_DCTRL: begin
                    r_d.dctrl = bus_wdata[CTL_W-1:0];
                    if (bus_wdata[0]) begin
                        r_d.dcnt       = r_q.dlen;
                        r_d.data_start = 1'b1;
                    end
                end
                W_MASK0:  r_d.mask[0] = bus_wdata;
                W_MASK1:  r_d.mask[1] = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    cardhost_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (status_set),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata[CLR_W-1:0]),
        .masks    (r_q.mask),
        .status   (status_q),
        .irq      (irq)
    );

    cardhost_rdmux u_rdmux (
        .idx        (idx),
        .r          (r_q),
        .status     (status_q),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .rdata      (bus_rdata)
    );

    assign irq_a      = irq[0];
    assign irq_b      = irq[1];
    assign cmd_start  = r_q.cmd_start;
    assign data_start = r_q.data_start;
    assign data_run   = r_q.dctrl[0] && !r_q.hold;
    assign fifo_push  = bus_wr && win && (r_q.dcnt != '0);
    assign fifo_wdata = bus_wdata;
    assign fifo_pop   = bus_rd && win && !fifo_empty;

    assign hold_q   = r_q.hold;
    assign cmd_en_q = r_q.cmd[CMD_EN];
    assign dcnt_q   = r_q.dcnt;

endmodule

// File: rtl/cardhost_regs_chk.sv
module cardhost_regs_chk
    import cardhost_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [IW-1:0]    idx,
    input logic             fifo_pop,
    input logic             fifo_empty,
    input logic             fifo_push,
    input logic             data_run,
    input logic             hold_q,
    input logic [LEN_W-1:0] dcnt_q,
    input logic [ST_W-1:0]  status_q,
    input logic             cmd_done,
    input logic             cmd_en_q
);
    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R8
    pop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !data_run);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (idx == W_STATUS || idx == W_FCNT)) |=> !hold_q);

    // R13
    push_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (dcnt_q != '0));

    // R7
    count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt_q == '0 && !(bus_wr && idx == W_DCTRL)) |=> (dcnt_q == '0));

    // R3
    high_status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q[ST_W-1:CLR_W] & $past(status_q[ST_W-1:CLR_W]))
                  == $past(status_q[ST_W-1:CLR_W])));

    // R10
    cmd_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !(bus_wr && idx == W_CMD)) |=> !cmd_en_q);

endmodule

bind cardhost_regs cardhost_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .idx        (idx),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .fifo_push  (fifo_push),
    .data_run   (data_run),
    .hold_q     (hold_q),
    .dcnt_q     (dcnt_q),
    .status_q   (status_q),
    .cmd_done   (cmd_done),
    .cmd_en_q   (cmd_en_q)
);

// File: tb/tb_cardhost_regs.sv
module tb_cardhost_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_a, irq_b, cmd_start, data_start, data_run;
    logic         cmd_done = 1'b0, resp_load = 1'b0, data_tick = 1'b0, data_idle = 1'b0;
    logic [5:0]   resp_cmd_in = '0;
    logic [127:0] resp_words = '0;
    logic [21:0]  status_set = '0;
    logic         fifo_push, fifo_pop;
    logic [31:0]  fifo_wdata;
    logic [31:0]  fifo_rdata = '0;
    logic         fifo_empty = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    logic last_push, last_pop;
    logic [31:0] last_wd;
    logic [31:0] v;

    always #2 clk = ~clk;

    cardhost_regs dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 last_push = fifo_push; last_wd = fifo_wdata;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; last_pop = fifo_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a <= 'h48; a += 4) begin
            rd(12'(a), v);
            check("R1 reg zero", v, 0);
        end
        check("R1 irq", {30'd0, irq_a, irq_b}, 0);
        check("R1 outs", {27'd0, cmd_start, data_start, data_run, fifo_push, fifo_pop}, 0);
    endtask

    task automatic t_widths();
        wr(12'h000, 32'hABCD); rd(12'h000, v); check("R2 power", v, 32'hCD);
        wr(12'h004, 32'h1234); rd(12'h004, v); check("R2 clock", v, 32'h34);
        wr(12'h028, 32'h12345); rd(12'h028, v); check("R2 dlen", v, 32'h2345);
        wr(12'h02C, 32'h1F2); rd(12'h02C, v); check("R2 dctrl", v, 32'hF2);
        wr(12'h008, 32'hCAFEF00D); rd(12'h008, v); check("R2 arg", v, 32'hCAFEF00D);
        wr(12'h024, 32'h8765_4321); rd(12'h024, v); check("R2 dtimer", v, 32'h87654321);
        wr(12'h02C, 32'h0);
    endtask

    task automatic t_status();
        @(negedge clk); status_set = 22'h3FFFFF;
        @(negedge clk); status_set = '0;
        rd(12'h034, v); check("R3 all set", v, 32'h3FFFFF);
        wr(12'h038, 32'hFFFFFFFF);
        rd(12'h034, v); check("R3 only low clear", v, 32'h3FF800);
        wr(12'h03C, 32'h0000_0800); wr(12'h040, 32'h0000_0001);
        check("R4 irq_a on", 32'(irq_a), 1);
        check("R4 irq_b off", 32'(irq_b), 0);
        rd(12'h03C, v); check("R2 mask0", v, 32'h800);
        @(negedge clk);
        status_set = 22'h1; bus_addr = 12'h038; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        status_set = '0; bus_wr = 1'b0;
        rd(12'h034, v); check("R3 set beats clear", v & 32'h1, 1);
        check("R4 irq_b on", 32'(irq_b), 1);
        wr(12'h038, 32'h1);
        check("R4 irq_b off again", 32'(irq_b), 0);
        wr(12'h03C, 32'h0); wr(12'h040, 32'h0);
        check("R4 both off", {30'd0, irq_a, irq_b}, 0);
    endtask

    task automatic t_id();
        logic [7:0] exp [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(4*k), v);
            check("R5 id", v, {24'd0, exp[k]});
        end
    endtask

    task automatic load_count(input logic [15:0] len);
        wr(12'h028, {16'd0, len});
        wr(12'h02C, 32'h1);
    endtask

    task automatic t_fcnt();
        load_count(16'd0); rd(12'h048, v); check("R6 len0", v, 0);
        load_count(16'd4); rd(12'h048, v); check("R6 len4", v, 1);
        load_count(16'd5); rd(12'h048, v); check("R6 len5", v, 2);
        load_count(16'hFFFF); rd(12'h048, v); check("R6 max", v, 32'h4000);
    endtask

    task automatic t_data();
        wr(12'h028, 32'd9);
        wr(12'h02C, 32'h3);
        check("R7 start pulse", 32'(data_start), 1);
        check("R9 run", 32'(data_run), 1);
        rd(12'h030, v); check("R7 load", v, 9);
        check("R7 pulse once", 32'(data_start), 0);
        @(negedge clk); data_tick = 1'b1;
        @(negedge clk); @(negedge clk); data_tick = 1'b0;
        rd(12'h030, v); check("R7 dec", v, 7);
        rd(12'h048, v); check("R6 words", v, 2);
        wr(12'h090, 32'h55AA0001);
        check("R13 push", 32'(last_push), 1);
        check("R13 wdata", last_wd, 32'h55AA0001);
        @(negedge clk); data_tick = 1'b1;
        repeat (10) @(negedge clk);
        data_tick = 1'b0;
        rd(12'h030, v); check("R7 floor", v, 0);
        wr(12'h080, 32'h1);
        check("R13 no push", 32'(last_push), 0);
        @(negedge clk); data_idle = 1'b1;
        @(negedge clk); data_idle = 1'b0;
        rd(12'h02C, v); check("R14 idle", v, 32'h2);
        check("R9 run off", 32'(data_run), 0);
    endtask

    task automatic t_hold();
        wr(12'h028, 32'd64);
        wr(12'h02C, 32'h1);
        fifo_empty = 1'b0; fifo_rdata = 32'hDEADBEEF;
        rd(12'h084, v);
        check("R8 data", v, 32'hDEADBEEF);
        check("R8 pop", 32'(last_pop), 1);
        check("R8 hold", 32'(data_run), 0);
        rd(12'h034, v);
        check("R9 status release", 32'(data_run), 1);
        rd(12'h0BC, v);
        check("R8 hold 2", 32'(data_run), 0);
        rd(12'h048, v);
        check("R9 count release", 32'(data_run), 1);
        fifo_empty = 1'b1;
        rd(12'h080, v);
        check("R8 empty data", v, 0);
        check("R8 empty no pop", 32'(last_pop), 0);
        check("R8 empty no hold", 32'(data_run), 1);
        wr(12'h02C, 32'h0);
    endtask

    task automatic t_cmd();
        wr(12'h00C, 32'h0000_04C5);
        check("R10 start", 32'(cmd_start), 1);
        rd(12'h00C, v); check("R10 en held", v, 32'h4C5);
        check("R10 one pulse", 32'(cmd_start), 0);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        rd(12'h00C, v); check("R10 en cleared", v, 32'hC5);
        wr(12'h00C, 32'h0000_0033);
        check("R10 no start", 32'(cmd_start), 0);
    endtask

    task automatic t_resp();
        @(negedge clk);
        resp_load = 1'b1; resp_cmd_in = 6'h2A;
        resp_words = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
        @(negedge clk); resp_load = 1'b0;
        rd(12'h010, v); check("R11 rcmd", v, 32'h2A);
        rd(12'h014, v); check("R11 w0", v, 32'h11111111);
        rd(12'h020, v); check("R11 w3", v, 32'h44444444);
    endtask

    task automatic t_unmapped();
        wr(12'h000, 32'h5A);
        wr(12'h044, 32'hFFFFFFFF);
        wr(12'h04C, 32'hFFFFFFFF);
        wr(12'h0C0, 32'hFFFFFFFF);
        rd(12'h044, v); check("R12 rd 44", v, 0);
        rd(12'h0C0, v); check("R12 rd C0", v, 0);
        rd(12'h000, v); check("R12 power kept", v, 32'h5A);
        rd(12'h03C, v); check("R12 mask kept", v, 0);
        rd(12'h034, v); check("R12 status kept", v, 32'h3FF800);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_widths();
        t_status();
        t_id();
        t_fcnt();
        t_data();
        t_hold();
        t_cmd();
        t_resp();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule